// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block decides which of four memory chip selects owns a physical address. Each chip select has one 32-bit bounds word, written and read back through a small register port. The word holds a first and a last region number, both counted in 16 MiB units. A lookup presents a 40-bit byte address. One clock later the block returns one of two results: a hit flag with the index of the owning chip select, or an out-of-range flag when no populated chip select covers the address.

A memory controller's address path uses the block before row, bank and column mapping. Error-reporting logic also uses it to attribute a captured failing address to a chip select. The last region named in a bounds word belongs to the chip select, so the covered span ends one byte before the following 16 MiB boundary. A bounds word whose two fields are equal marks an empty socket. If ranges overlap, the lowest-numbered chip select wins.

Top module: `cs_range_decoder`

## Requirements
- R1: There are four 32-bit bounds words, selected by a 2-bit index `cfg_idx`. A write with `cfg_we` high stores `cfg_wdata` at the next clock edge. `cfg_rdata` shows, combinationally, the word currently selected by `cfg_idx`. All words reset to 0.
- R2: In a bounds word, bits 31:16 hold the first region number and bits 15:0 hold the last region number.
- R3: A region is 16 MiB. The address belongs to region `req_addr[39:24]`. Address bits 23:0 never change which chip select is chosen.
- R4: A populated chip select covers every byte address from first×2^24 through (last+1)×2^24 − 1, both ends included.
- R5: A chip select whose first and last fields are equal is unpopulated and never matches. After reset, every lookup therefore reports out of range.
- R6: When no chip select matches, the response has `rsp_miss`=1, `rsp_hit`=0 and `rsp_cs`=0. A chip select whose first field is greater than its last field covers nothing.
- R7: When several chip selects match, `rsp_cs` is the lowest-numbered one.
- R8: The result is registered. `rsp_valid` equals `req_valid` delayed by one clock. When `rsp_valid` is 0, `rsp_hit` and `rsp_miss` are 0 and `rsp_cs` is 0.
- R9: A lookup in the same cycle as a bounds write is decoded with the contents from before the write. The new contents apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bounds word write strobe |
| cfg_idx | input | 2 | Bounds word index for write and read |
| cfg_wdata | input | 32 | Write data: first region in 31:16, last region in 15:0 |
| cfg_rdata | output | 32 | Read data of the word selected by `cfg_idx` |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 40 | Byte address to decode |
| rsp_valid | output | 1 | Lookup result present (one cycle after the request) |
| rsp_hit | output | 1 | A populated chip select covers the address |
| rsp_miss | output | 1 | No populated chip select covers the address |
| rsp_cs | output | 2 | Index of the owning chip select on a hit, else 0 |

## Verification
The bound checker watches every result on every cycle. It checks that a hit lies inside the selected chip select's range as it stood in the request cycle, and that the selected chip select is populated. It checks that no lower-numbered chip select also matched, and that a miss means no chip select matched at all. It also checks that the valid output trails the request by one cycle and that hit and miss are mutually exclusive and quiet when idle. Only the bench's scenarios can show the rest: that writes land in the right word and read back, that the exact byte just before a 16 MiB boundary is still covered while the next byte is not, that reversed ranges are empty, and that a write in the lookup cycle does not yet apply.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    // Width of one region field inside a bounds word.
    localparam int CS_FIELD_W = 16;
    // Width of a bounds word.
    localparam int CS_WORD_W  = 2 * CS_FIELD_W;

    // Bounds word layout: first region in the upper half, last region in the lower half.
    typedef struct packed {
        logic [CS_FIELD_W-1:0] first;
        logic [CS_FIELD_W-1:0] last;
    } cs_bound_t;

endpackage

// File: rtl/cs_bounds_regs.sv
module cs_bounds_regs
    import cs_dec_pkg::*;
#(
    parameter  int NUM_CS = 4,
    localparam int IDX_W  = $clog2(NUM_CS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic [CS_WORD_W-1:0]        wdata,
    output logic [CS_WORD_W-1:0]        rdata,
    output logic [NUM_CS*CS_WORD_W-1:0] words_flat
);

    logic [CS_WORD_W-1:0] words_d [NUM_CS];
    logic [CS_WORD_W-1:0] words_q [NUM_CS];

    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            words_d[i] = words_q[i];
        end
        if (we) begin
            words_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                words_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_CS; i++) begin
                words_q[i] <= words_d[i];
            end
        end
    end

    assign rdata = words_q[idx];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_flat
        assign words_flat[g*CS_WORD_W +: CS_WORD_W] = words_q[g];
    end

endmodule

// File: rtl/cs_range_match.sv
module cs_range_match
    import cs_dec_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int ADDR_W     = 40,
    parameter int GRAN_SHIFT = 24
) (
    input  logic [NUM_CS*CS_WORD_W-1:0] words_flat,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NUM_CS-1:0]           match
);

    localparam int PAD_W = ADDR_W - GRAN_SHIFT - CS_FIELD_W;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        cs_bound_t         bnd;
        logic [ADDR_W-1:0] lo_byte;
        logic [ADDR_W-1:0] hi_byte;
        logic              populated;

        assign bnd       = words_flat[g*CS_WORD_W +: CS_WORD_W];
        assign populated = (bnd.first != bnd.last);
        // Byte-exact window; the constant low bits fold away in synthesis.
        assign lo_byte   = {{PAD_W{1'b0}}, bnd.first, {GRAN_SHIFT{1'b0}}};
        assign hi_byte   = {{PAD_W{1'b0}}, bnd.last,  {GRAN_SHIFT{1'b1}}};
        assign match[g]  = populated && (addr >= lo_byte) && (addr <= hi_byte);
    end

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
    parameter  int N     = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cs_range_decoder.sv
module cs_range_decoder
    import cs_dec_pkg::*;
#(
    parameter  int NUM_CS     = 4,
    parameter  int ADDR_W     = 40,
    parameter  int GRAN_SHIFT = 24,
    localparam int IDX_W      = $clog2(NUM_CS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [CS_WORD_W-1:0] cfg_wdata,
    output logic [CS_WORD_W-1:0] cfg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [IDX_W-1:0]     rsp_cs
);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic [IDX_W-1:0] cs;
    } rsp_t;

    logic [NUM_CS*CS_WORD_W-1:0] words_flat;
    logic [NUM_CS-1:0]           match;
    logic                        any_match;
    logic [IDX_W-1:0]            win_idx;
    rsp_t                        rsp_d;
    rsp_t                        rsp_q;

    cs_bounds_regs #(
        .NUM_CS (NUM_CS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .words_flat (words_flat)
    );

    cs_range_match #(
        .NUM_CS     (NUM_CS),
        .ADDR_W     (ADDR_W),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) u_match (
        .words_flat (words_flat),
        .addr       (req_addr),
        .match      (match)
    );

    cs_prio_pick #(
        .N (NUM_CS)
    ) u_pick (
        .req (match),
        .any (any_match),
        .idx (win_idx)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = any_match;
            rsp_d.miss  = !any_match;
            rsp_d.cs    = any_match ? win_idx : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_cs    = rsp_q.cs;

endmodule

// File: rtl/cs_range_decoder_chk.sv
module cs_range_decoder_chk
    import cs_dec_pkg::*;
#(
    parameter  int NUM_CS     = 4,
    parameter  int ADDR_W     = 40,
    parameter  int GRAN_SHIFT = 24,
    localparam int IDX_W      = $clog2(NUM_CS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [NUM_CS*CS_WORD_W-1:0] words_flat,
    input logic                        rsp_valid,
    input logic                        rsp_hit,
    input logic                        rsp_miss,
    input logic [IDX_W-1:0]            rsp_cs
);

    logic [ADDR_W-1:0]           prev_addr;
    logic [NUM_CS*CS_WORD_W-1:0] prev_words;
    logic [ADDR_W-1:0]           prev_region;
    logic [NUM_CS-1:0]           prev_match;
    logic                        sel_populated;
    logic                        sel_in_range;
    logic                        lower_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr  <= '0;
            prev_words <= '0;
        end else begin
            prev_addr  <= req_addr;
            prev_words <= words_flat;
        end
    end

    assign prev_region = prev_addr >> GRAN_SHIFT;

    always_comb begin
        cs_bound_t b;
        for (int i = 0; i < NUM_CS; i++) begin
            b = prev_words[i*CS_WORD_W +: CS_WORD_W];
            prev_match[i] = (b.first != b.last)
                         && (prev_region >= ADDR_W'(b.first))
                         && (prev_region <= ADDR_W'(b.last));
        end
        b = prev_words[rsp_cs*CS_WORD_W +: CS_WORD_W];
        sel_populated = (b.first != b.last);
        sel_in_range  = (prev_region >= ADDR_W'(b.first)) && (prev_region <= ADDR_W'(b.last));
        lower_match   = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (IDX_W'(i) < rsp_cs && prev_match[i]) begin
                lower_match = 1'b1;
            end
        end
    end

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_cs == '0));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    a_r4_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> sel_in_range);
    a_r5_hit_populated: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> sel_populated);
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !lower_match);
    a_r6_miss_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (prev_match == '0));

endmodule

bind cs_range_decoder cs_range_decoder_chk #(
    .NUM_CS     (NUM_CS),
    .ADDR_W     (ADDR_W),
    .GRAN_SHIFT (GRAN_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .words_flat (words_flat),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_cs     (rsp_cs)
);

// File: tb/cs_range_decoder_bench.sv
module cs_range_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_miss;
    logic [1:0]  rsp_cs;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model of the bounds words.
    logic [31:0] model [4];

    always #4 clk = ~clk;

    cs_range_decoder u_cs_range_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_cs    (rsp_cs)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected decode: returns {hit, cs}.
    function automatic logic [2:0] expect_decode(input logic [39:0] addr);
        logic [15:0] region;
        region = addr[39:24];
        for (int i = 0; i < 4; i++) begin
            if (model[i][31:16] != model[i][15:0]
                && region >= model[i][31:16] && region <= model[i][15:0]) begin
                return {1'b1, 2'(i)};
            end
        end
        return 3'b000;
    endfunction

    task automatic write_word(input int idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 2'(idx);
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
        model[idx] = val;
    endtask

    task automatic lookup(input string req, input logic [39:0] addr);
        logic [2:0] exp;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        exp = expect_decode(addr);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {60'd0, rsp_valid, rsp_hit, rsp_miss, 1'b0},
                   {60'd0, 1'b1, exp[2], !exp[2], 1'b0});
        check(req, {62'd0, rsp_cs}, {62'd0, exp[1:0]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R1, R8
        @(negedge clk);
        check("R8 idle after reset", {63'd0, rsp_valid}, 64'd0);
        for (int i = 0; i < 4; i++) begin
            cfg_idx = 2'(i);
            #1;
            check("R1 reset word", {32'd0, cfg_rdata}, 64'd0);
        end
        // R5: all unpopulated after reset
        lookup("R5 reset miss", 40'h00_0000_0000);
        lookup("R5 reset miss high", 40'h12_3456_789a);

        // R1/R2 write and readback
        write_word(0, {16'h0000, 16'h0003});
        write_word(1, {16'h0004, 16'h0007});
        write_word(2, {16'h0010, 16'h0010});
        write_word(3, {16'h0030, 16'h0020});
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_idx = 2'(i);
            #1;
            check("R1 readback", {32'd0, cfg_rdata}, {32'd0, model[i]});
        end

        // R4 boundaries, R3 low bits ignored, R2 field order
        lookup("R4 first byte cs0", 40'h00_0000_0000);
        lookup("R4 last byte cs0",  40'h00_03ff_ffff);
        lookup("R4 first byte cs1", 40'h00_0400_0000);
        lookup("R4 last byte cs1",  40'h00_07ff_ffff);
        lookup("R4 past end cs1",   40'h00_0800_0000);
        lookup("R3 low bits cs1",   40'h00_05a5_a5a5);
        // R5 equal fields nonzero, R6 reversed range
        lookup("R5 unpopulated cs2", 40'h00_1000_0000);
        lookup("R6 reversed cs3",    40'h00_2500_0000);
        lookup("R6 top address",     40'hff_ffff_ffff);

        // R7 overlap: cs1 and cs3 both cover 0x06
        write_word(3, {16'h0006, 16'h0040});
        lookup("R7 overlap lower wins", 40'h00_0600_0000);
        lookup("R7 only cs3",           40'h00_0800_0000);
        lookup("R4 last byte cs3",      40'h00_40ff_ffff);
        lookup("R6 past cs3",           40'h00_4100_0000);

        // R9: write in the same cycle as a lookup uses the old contents
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 2'd2;
        cfg_wdata = {16'h0050, 16'h0052};
        req_valid = 1'b1;
        req_addr  = 40'h00_5100_0000;
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
        check("R9 old contents used", {61'd0, rsp_hit, rsp_miss, 1'b0}, {61'd0, 1'b0, 1'b1, 1'b0});
        model[2] = {16'h0050, 16'h0052};
        lookup("R9 new contents next", 40'h00_5100_0000);

        // R8: valid drops one cycle after request drops
        @(negedge clk);
        check("R8 idle outputs", {60'd0, rsp_valid, rsp_hit, rsp_miss, 1'b0}, 64'd0);
        check("R8 idle cs", {62'd0, rsp_cs}, 64'd0);

        // Random bounds and addresses, biased toward boundaries: R3 R4 R6 R7
        for (int round = 0; round < 40; round++) begin
            for (int i = 0; i < 4; i++) begin
                logic [15:0] f;
                logic [15:0] l;
                f = 16'($urandom_range(0, 63));
                l = ($urandom_range(0, 7) == 0) ? f : 16'($urandom_range(0, 63));
                write_word(i, {f, l});
            end
            for (int k = 0; k < 8; k++) begin
                int          c;
                logic [15:0] reg_n;
                c = $urandom_range(0, 3);
                case ($urandom_range(0, 3))
                    0: reg_n = model[c][31:16];
                    1: reg_n = model[c][15:0];
                    2: reg_n = model[c][15:0] + 16'd1;
                    default: reg_n = model[c][31:16] - 16'd1;
                endcase
                lookup("R7 random decode", {reg_n, 24'($urandom)});
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule